// File: doc/BRIEF.md
# Nested Fault Escalation Resolver

This block decides how a processor core handles a CPU exception raised while an earlier event is still being delivered. Each request presents two events. The earlier event has a kind and a vector. The new exception has a kind, a vector and an optional error code. One cycle later the block returns a single response pulse that carries:

- an outcome code,
- a one-hot-style diagnostic info mask,
- the vector and error code the dispatcher should actually deliver, and
- a shutdown flag.

Each vector is sorted into one of three classes: benign, contributory or page-fault. The pair of classes picks the outcome. The pair can escalate to a double fault or a triple fault, or it can report a stuck recursive alignment-check condition.

When the new exception results from an external event, the resolver sets the external-origin flag in the error code. It also tracks how deep the delivery recursion goes, and it aborts once the limit is reached. The dispatcher sends a completion pulse when delivery finishes, which clears the depth. Walking descriptor tables, pushing stack frames and sequencing a shutdown are left to the surrounding logic.

Top module: `fault_nest_resolver`

## Requirements
- R1: Vectors 0, 10, 11, 12, 13 and 30 are contributory. Vectors 14 and 20 are page-fault class. Every other vector is benign. Event kinds are encoded 0 none, 1 CPU exception, 2 external interrupt, 3 software interrupt.
- R2: When the new event's kind is not 1, the outcome is 7 (invalid) and the info mask is 0x01.
- R3: An earlier page-fault-class exception followed by a page-fault-class exception gives outcome 3 (double fault) with info 0x04. When it is followed by a contributory exception, the outcome is 3 with info 0x08.
- R4: Contributory followed by contributory gives outcome 3 with info 0x01. Contributory followed by a page-fault-class exception delivers the new exception: outcome 0, info 0x01.
- R5: An earlier vector 8 (double fault) followed by a contributory or page-fault-class exception gives outcome 4 (triple fault). When it is followed by a benign exception, the new exception is delivered with outcome 0.
- R6: An earlier benign exception gives outcome 0 with info 0x01, with two exceptions. Vector 2 followed by vector 14 gives info 0x80 only. Vector 17 followed by vector 17 gives outcome 5 (hang) with info 0x02.
- R7: An earlier external interrupt gives outcome 0 with info 0x10, or with info 0x30 when the new vector is 14. An earlier software interrupt gives outcome 0 with info 0x40.
- R8: On outcome 3 the delivered vector is 8, the error code is zero and the error-valid flag is 1.
- R9: Bit 0 of the delivered error code is set when all of these hold: the earlier kind is 1 or 2, the delivered error is valid, and the delivered vector is neither 14 nor 8. Otherwise the delivered error code equals the presented error code.
- R10: The block counts requests accepted since the last completion pulse. A request that arrives while the count is already 3 is aborted: shutdown is 1, outcome is 4, info is 0x01, the vector and error are passed unchanged, and the count is kept. A completion pulse clears the count before any request in the same cycle is evaluated.
- R11: A response is a single-cycle pulse one clock after the request. Nothing is valid after reset.
- R12: With no earlier event (kind 0), the new CPU exception is delivered unchanged: outcome 0, info 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| prev_kind | input | 2 | Kind of earlier event |
| prev_vec | input | VEC_W | Vector of earlier event |
| cur_kind | input | 2 | Kind of new event |
| cur_vec | input | VEC_W | Vector of new event |
| cur_err_vld | input | 1 | New event carries an error code |
| cur_err | input | ERR_W | Error code of new event |
| done_pulse | input | 1 | Delivery completed; clears depth |
| rsp_valid | output | 1 | Response pulse |
| rsp_outcome | output | 3 | Outcome code |
| rsp_info | output | 8 | Diagnostic info mask |
| rsp_vec | output | VEC_W | Vector to deliver |
| rsp_err_vld | output | 1 | Delivered error code valid |
| rsp_err | output | ERR_W | Error code to deliver |
| rsp_shutdown | output | 1 | Depth limit abort |

## Verification
The assertions watch, on every cycle, the rules that have a fixed shape:

- the response pulse timing;
- the shape of the double-fault replacement;
- the invalid outcome for non-exception kinds;
- pass-through when there is no earlier event;
- the pairing of the alignment-check info bit with the hang outcome;
- that a completion pulse prevents an abort.

Only the bench scenarios can show the full class matrix, the triple-fault and external-bit cases, and the depth limit. In those scenarios the bench walks specific vector pairs and builds up a run of requests with no completion pulse between them.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
   typedef enum logic [1:0] {
      EVK_NONE = 2'd0,
      EVK_CPU  = 2'd1,
      EVK_EXT  = 2'd2,
      EVK_SOFT = 2'd3
   } evk_e;

   typedef enum logic [1:0] {
      CLS_BENIGN  = 2'd0,
      CLS_CONTRIB = 2'd1,
      CLS_PAGE    = 2'd2
   } cls_e;

   typedef enum logic [2:0] {
      RES_DELIVER = 3'd0,
      RES_DOUBLE  = 3'd3,
      RES_TRIPLE  = 3'd4,
      RES_HANG    = 3'd5,
      RES_INVALID = 3'd7
   } res_e;

   localparam int INFO_W    = 8;
   localparam int INF_NONE  = 0;
   localparam int INF_ACAC  = 1;
   localparam int INF_PFPF  = 2;
   localparam int INF_PFCON = 3;
   localparam int INF_EXTX  = 4;
   localparam int INF_EXTPF = 5;
   localparam int INF_SOFTX = 6;
   localparam int INF_NMIPF = 7;

   localparam int V_DE  = 0;
   localparam int V_NMI = 2;
   localparam int V_DF  = 8;
   localparam int V_TS  = 10;
   localparam int V_NP  = 11;
   localparam int V_SS  = 12;
   localparam int V_GP  = 13;
   localparam int V_PF  = 14;
   localparam int V_AC  = 17;
   localparam int V_VE  = 20;
   localparam int V_SX  = 30;
endpackage

// File: rtl/fnr_vec_class.sv
module fnr_vec_class
   import fnr_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter bit HAS_VE = 1'b1,
   parameter bit HAS_SX = 1'b1
) (
   input  logic [VEC_W-1:0] vec,
   output cls_e             cls
);
   logic ve_hit;
   logic sx_hit;
   logic con_hit;
   logic pg_hit;

   generate
      if (HAS_VE) begin : g_ve
         assign ve_hit = (vec == VEC_W'(V_VE));
      end else begin : g_no_ve
         assign ve_hit = 1'b0;
      end
      if (HAS_SX) begin : g_sx
         assign sx_hit = (vec == VEC_W'(V_SX));
      end else begin : g_no_sx
         assign sx_hit = 1'b0;
      end
   endgenerate

   assign con_hit = (vec == VEC_W'(V_DE)) || (vec == VEC_W'(V_TS)) ||
                    (vec == VEC_W'(V_NP)) || (vec == VEC_W'(V_SS)) ||
                    (vec == VEC_W'(V_GP)) || sx_hit;
   assign pg_hit  = (vec == VEC_W'(V_PF)) || ve_hit;

   always_comb begin
      if (pg_hit)       cls = CLS_PAGE;
      else if (con_hit) cls = CLS_CONTRIB;
      else              cls = CLS_BENIGN;
   end
endmodule

// File: rtl/fnr_escalate.sv
module fnr_escalate
   import fnr_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  evk_e              prev_k,
   input  logic [VEC_W-1:0]  prev_v,
   input  cls_e              prev_c,
   input  evk_e              cur_k,
   input  logic [VEC_W-1:0]  cur_v,
   input  cls_e              cur_c,
   output res_e              res,
   output logic [INFO_W-1:0] info
);
   always_comb begin
      res  = RES_DELIVER;
      info = '0;
      if (cur_k != EVK_CPU) begin
         res = RES_INVALID;
      end else begin
         unique case (prev_k)
            EVK_CPU: begin
               if (prev_c == CLS_PAGE) begin
                  if (cur_c == CLS_PAGE) begin
                     res = RES_DOUBLE;
                     info[INF_PFPF] = 1'b1;
                  end else if (cur_c == CLS_CONTRIB) begin
                     res = RES_DOUBLE;
                     info[INF_PFCON] = 1'b1;
                  end
               end else if (prev_c == CLS_CONTRIB) begin
                  if (cur_c == CLS_CONTRIB) res = RES_DOUBLE;
               end else if (prev_v == VEC_W'(V_DF)) begin
                  if (cur_c != CLS_BENIGN) res = RES_TRIPLE;
               end else if (prev_v == VEC_W'(V_NMI) && cur_v == VEC_W'(V_PF)) begin
                  info[INF_NMIPF] = 1'b1;
               end else if (prev_v == VEC_W'(V_AC) && cur_v == VEC_W'(V_AC)) begin
                  res = RES_HANG;
                  info[INF_ACAC] = 1'b1;
               end
            end
            EVK_EXT: begin
               info[INF_EXTX] = 1'b1;
               if (cur_v == VEC_W'(V_PF)) info[INF_EXTPF] = 1'b1;
            end
            EVK_SOFT: info[INF_SOFTX] = 1'b1;
            default: ;
         endcase
      end
      if (info == '0) info[INF_NONE] = 1'b1;
   end
endmodule

// File: rtl/fnr_final.sv
module fnr_final
   import fnr_pkg::*;
#(
   parameter int VEC_W = 8,
   parameter int ERR_W = 32
) (
   input  res_e             res,
   input  evk_e             prev_k,
   input  logic [VEC_W-1:0] cur_v,
   input  logic             cur_ev,
   input  logic [ERR_W-1:0] cur_e,
   output logic [VEC_W-1:0] fin_v,
   output logic             fin_ev,
   output logic [ERR_W-1:0] fin_e
);
   logic ext_src;
   assign ext_src = (prev_k == EVK_CPU) || (prev_k == EVK_EXT);

   always_comb begin
      if (res == RES_DOUBLE) begin
         fin_v  = VEC_W'(V_DF);
         fin_ev = 1'b1;
         fin_e  = '0;
      end else begin
         fin_v  = cur_v;
         fin_ev = cur_ev;
         fin_e  = cur_e;
      end
      if (res != RES_INVALID && ext_src && fin_ev &&
          fin_v != VEC_W'(V_PF) && fin_v != VEC_W'(V_DF))
         fin_e[0] = 1'b1;
   end
endmodule

// File: rtl/fnr_nest_cnt.sv
module fnr_nest_cnt #(
   parameter int MAX_NEST = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic done,
   output logic abort
);
   localparam int CNT_W = $clog2(MAX_NEST + 1);

   logic [CNT_W-1:0] depth_q;
   logic [CNT_W-1:0] depth_eff;

   assign depth_eff = done ? '0 : depth_q;
   assign abort     = req && (depth_eff >= CNT_W'(MAX_NEST));

   always_ff @(posedge clk) begin
      if (!rst_n)            depth_q <= '0;
      else if (req && !abort) depth_q <= depth_eff + CNT_W'(1);
      else                   depth_q <= depth_eff;
   end
endmodule

// File: rtl/fault_nest_resolver.sv
module fault_nest_resolver
   import fnr_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int ERR_W    = 32,
   parameter int MAX_NEST = 3,
   parameter bit HAS_VE   = 1'b1,
   parameter bit HAS_SX   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       prev_kind,
   input  logic [VEC_W-1:0] prev_vec,
   input  logic [1:0]       cur_kind,
   input  logic [VEC_W-1:0] cur_vec,
   input  logic             cur_err_vld,
   input  logic [ERR_W-1:0] cur_err,
   input  logic             done_pulse,
   output logic             rsp_valid,
   output logic [2:0]       rsp_outcome,
   output logic [7:0]       rsp_info,
   output logic [VEC_W-1:0] rsp_vec,
   output logic             rsp_err_vld,
   output logic [ERR_W-1:0] rsp_err,
   output logic             rsp_shutdown
);
   generate
      if (VEC_W < 5) begin : g_bad_vec
         $error("VEC_W too small for vector 30");
      end
      if (ERR_W < 1) begin : g_bad_err
         $error("ERR_W must be positive");
      end
      if (MAX_NEST < 1) begin : g_bad_nest
         $error("MAX_NEST must be positive");
      end
   endgenerate

   evk_e              pk, ck;
   cls_e              pc, cc;
   res_e              res;
   logic [INFO_W-1:0] info;
   logic [VEC_W-1:0]  fin_v;
   logic              fin_ev;
   logic [ERR_W-1:0]  fin_e;
   logic              abort;

   assign pk = evk_e'(prev_kind);
   assign ck = evk_e'(cur_kind);

   fnr_vec_class #(.VEC_W(VEC_W), .HAS_VE(HAS_VE), .HAS_SX(HAS_SX)) prev_cls_i (
      .vec(prev_vec), .cls(pc));
   fnr_vec_class #(.VEC_W(VEC_W), .HAS_VE(HAS_VE), .HAS_SX(HAS_SX)) cur_cls_i (
      .vec(cur_vec), .cls(cc));

   fnr_escalate #(.VEC_W(VEC_W)) esc_i (
      .prev_k(pk), .prev_v(prev_vec), .prev_c(pc),
      .cur_k(ck), .cur_v(cur_vec), .cur_c(cc),
      .res(res), .info(info));

   fnr_final #(.VEC_W(VEC_W), .ERR_W(ERR_W)) fin_i (
      .res(res), .prev_k(pk), .cur_v(cur_vec), .cur_ev(cur_err_vld), .cur_e(cur_err),
      .fin_v(fin_v), .fin_ev(fin_ev), .fin_e(fin_e));

   fnr_nest_cnt #(.MAX_NEST(MAX_NEST)) cnt_i (
      .clk(clk), .rst_n(rst_n), .req(req_valid), .done(done_pulse), .abort(abort));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_outcome  <= '0;
         rsp_info     <= '0;
         rsp_vec      <= '0;
         rsp_err_vld  <= 1'b0;
         rsp_err      <= '0;
         rsp_shutdown <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_shutdown <= abort;
         if (req_valid) begin
            if (abort) begin
               rsp_outcome <= RES_TRIPLE;
               rsp_info    <= 8'h01;
               rsp_vec     <= cur_vec;
               rsp_err_vld <= cur_err_vld;
               rsp_err     <= cur_err;
            end else begin
               rsp_outcome <= res;
               rsp_info    <= info;
               rsp_vec     <= fin_v;
               rsp_err_vld <= fin_ev;
               rsp_err     <= fin_e;
            end
         end
      end
   end
endmodule

// File: rtl/fnr_checker.sv
module fnr_checker #(
   parameter int VEC_W = 8,
   parameter int ERR_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       prev_kind,
   input logic [1:0]       cur_kind,
   input logic [VEC_W-1:0] cur_vec,
   input logic [ERR_W-1:0] cur_err,
   input logic             done_pulse,
   input logic             rsp_valid,
   input logic [2:0]       rsp_outcome,
   input logic [7:0]       rsp_info,
   input logic [VEC_W-1:0] rsp_vec,
   input logic             rsp_err_vld,
   input logic [ERR_W-1:0] rsp_err,
   input logic             rsp_shutdown
);
   // R11
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R11
   rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R8
   df_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_shutdown && rsp_outcome == 3'd3) |->
      (rsp_vec == VEC_W'(8) && rsp_err_vld && rsp_err == '0));
   // R2
   bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && cur_kind != 2'd1) |=> (rsp_shutdown || rsp_outcome == 3'd7));
   // R10
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !rsp_shutdown);
   // R12
   no_prev_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && prev_kind == 2'd0 && cur_kind == 2'd1) |=>
      (rsp_shutdown || (rsp_outcome == 3'd0 && rsp_vec == $past(cur_vec) &&
                        rsp_err == $past(cur_err) && rsp_info == 8'h01)));
   // R6
   acac_hang_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_info[1]) |-> rsp_outcome == 3'd5);
endmodule

bind fault_nest_resolver fnr_checker #(.VEC_W(VEC_W), .ERR_W(ERR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prev_kind(prev_kind),
   .cur_kind(cur_kind), .cur_vec(cur_vec), .cur_err(cur_err), .done_pulse(done_pulse),
   .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_info(rsp_info),
   .rsp_vec(rsp_vec), .rsp_err_vld(rsp_err_vld), .rsp_err(rsp_err),
   .rsp_shutdown(rsp_shutdown));

// File: tb/fault_nest_resolver_tb_top.sv
module fault_nest_resolver_tb_top;
   localparam int VW = 8;
   localparam int EW = 32;
   localparam int RW = 3 + 8 + VW + 1 + EW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    prev_kind = '0;
   logic [VW-1:0] prev_vec = '0;
   logic [1:0]    cur_kind = '0;
   logic [VW-1:0] cur_vec = '0;
   logic          cur_err_vld = 1'b0;
   logic [EW-1:0] cur_err = '0;
   logic          done_pulse = 1'b0;
   logic          rsp_valid;
   logic [2:0]    rsp_outcome;
   logic [7:0]    rsp_info;
   logic [VW-1:0] rsp_vec;
   logic          rsp_err_vld;
   logic [EW-1:0] rsp_err;
   logic          rsp_shutdown;

   int total = 0;
   int bad = 0;
   int depth = 0;
   bit finished = 1'b0;
   logic [RW-1:0] exp_q[$];
   string         tag_q[$];

   always #5 clk = ~clk;

   fault_nest_resolver dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prev_kind(prev_kind),
      .prev_vec(prev_vec), .cur_kind(cur_kind), .cur_vec(cur_vec),
      .cur_err_vld(cur_err_vld), .cur_err(cur_err), .done_pulse(done_pulse),
      .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_info(rsp_info),
      .rsp_vec(rsp_vec), .rsp_err_vld(rsp_err_vld), .rsp_err(rsp_err),
      .rsp_shutdown(rsp_shutdown));

   function automatic int vclass(int v);
      if (v == 14 || v == 20) return 2;
      if (v == 0 || v == 10 || v == 11 || v == 12 || v == 13 || v == 30) return 1;
      return 0;
   endfunction

   function automatic logic [RW-1:0] model(int pk, int pv, int ck, int cv,
                                           bit ev, logic [EW-1:0] e, bit ab);
      logic [2:0] o = 3'd0;
      logic [7:0] inf = 8'h00;
      int fv = cv;
      bit fev = ev;
      logic [EW-1:0] fe = e;
      int pc = vclass(pv);
      int cc = vclass(cv);
      if (ab) return {3'd4, 8'h01, VW'(cv), ev, e, 1'b1};
      if (ck != 1) o = 3'd7;
      else if (pk == 1) begin
         if (pc == 2 && cc == 2) begin o = 3'd3; inf = 8'h04; end
         else if (pc == 2 && cc == 1) begin o = 3'd3; inf = 8'h08; end
         else if (pc == 1 && cc == 1) o = 3'd3;
         else if (pv == 8 && cc != 0) o = 3'd4;
         else if (pc == 0 && pv == 2 && cv == 14) inf = 8'h80;
         else if (pc == 0 && pv == 17 && cv == 17) begin o = 3'd5; inf = 8'h02; end
      end else if (pk == 2) inf = (cv == 14) ? 8'h30 : 8'h10;
      else if (pk == 3) inf = 8'h40;
      if (inf == 8'h00) inf = 8'h01;
      if (o == 3'd3) begin fv = 8; fev = 1'b1; fe = '0; end
      if (o != 3'd7 && (pk == 1 || pk == 2) && fev && fv != 14 && fv != 8) fe[0] = 1'b1;
      return {o, inf, VW'(fv), fev, fe, 1'b0};
   endfunction

   task automatic send(int pk, int pv, int ck, int cv, bit ev, logic [EW-1:0] e, string tag);
      bit ab;
      @(negedge clk);
      ab = (depth >= 3);
      if (!ab) depth++;
      req_valid = 1'b1; prev_kind = 2'(pk); prev_vec = VW'(pv);
      cur_kind = 2'(ck); cur_vec = VW'(cv); cur_err_vld = ev; cur_err = e;
      exp_q.push_back(model(pk, pv, ck, cv, ev, e, ab));
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_evt();
      @(negedge clk);
      done_pulse = 1'b1;
      depth = 0;
      @(negedge clk);
      done_pulse = 1'b0;
   endtask

   task automatic one(int pk, int pv, int ck, int cv, bit ev, logic [EW-1:0] e, string tag);
      send(pk, pv, ck, cv, ev, e, tag);
      finish_evt();
   endtask

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         logic [RW-1:0] act;
         logic [RW-1:0] exp;
         string t;
         act = {rsp_outcome, rsp_info, rsp_vec, rsp_err_vld, rsp_err, rsp_shutdown};
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R11 unexpected response act=%h exp=none", act);
         end else begin
            exp = exp_q.pop_front();
            t = tag_q.pop_front();
            if (act !== exp) begin
               bad++;
               $display("FAIL %s act=%h exp=%h", t, act, exp);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (rsp_valid !== 1'b0 || rsp_shutdown !== 1'b0) begin
         bad++;
         $display("FAIL R11 reset state act=%b%b exp=00", rsp_valid, rsp_shutdown);
      end
      one(0, 0, 1, 13, 1, 32'h10, "R12 no earlier event");
      one(1, 14, 1, 14, 1, 32'h6, "R3 PF then PF R8");
      one(1, 14, 1, 13, 1, 32'h20, "R3 PF then GP");
      one(1, 20, 1, 0, 0, 32'h0, "R1 VE then DE");
      one(1, 13, 1, 10, 1, 32'h18, "R4 GP then TS");
      one(1, 13, 1, 14, 1, 32'h2, "R4 GP then PF R9");
      one(1, 12, 1, 3, 0, 32'h0, "R4 SS then BP benign");
      one(1, 8, 1, 11, 1, 32'h20, "R5 DF then NP");
      one(1, 8, 1, 1, 0, 32'h0, "R5 DF then DB");
      one(1, 2, 1, 14, 1, 32'h4, "R6 NMI then PF");
      one(1, 17, 1, 17, 1, 32'h0, "R6 AC then AC R9");
      one(1, 6, 1, 13, 1, 32'h8, "R6 UD then GP R9");
      one(1, 30, 1, 30, 1, 32'h0, "R1 SX then SX");
      one(1, 14, 1, 6, 0, 32'h0, "R3 PF then benign");
      one(2, 64, 1, 14, 1, 32'h2, "R7 ext then PF");
      one(2, 64, 1, 13, 1, 32'h0, "R7 ext then GP R9");
      one(3, 128, 1, 13, 1, 32'h8, "R7 soft then GP R9");
      one(1, 13, 2, 32, 0, 32'h0, "R2 cur ext");
      one(0, 0, 3, 33, 1, 32'h1, "R2 cur soft");
      send(0, 0, 1, 13, 1, 32'h4, "R10 depth 1");
      send(1, 13, 1, 3, 0, 32'h0, "R10 depth 2");
      send(1, 3, 1, 6, 0, 32'h0, "R10 depth 3");
      send(1, 6, 1, 13, 1, 32'h8, "R10 abort");
      send(1, 6, 1, 13, 1, 32'h8, "R10 abort again");
      finish_evt();
      send(1, 13, 1, 12, 1, 32'h8, "R10 after clear");
      finish_evt();
      repeat (3) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R11 missing responses act=%0d exp=0", exp_q.size());
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule